// File: doc/BRIEF.md
# Block Limit Monitor and Status Word

This block watches a stream of calibrated, signed samples that arrive in blocks, one block per output cycle. A start marker opens a block and an end marker closes it. While a block is open, every valid sample is compared against two programmable signed thresholds. For each threshold the block notes whether any sample came at or below it and whether any sample came at or above it. The block also notes whether any sample sat at either saturation value. Internal-error and sync-error indications seen during the block are collected as well.

When the block closes, the collected results are registered once. Each threshold gets a 2-bit result code, and a 16-bit status word is published. Both are held until the next block closes. A bit in the status word flips on every publish, so a consumer can tell a fresh value from a repeated one.

Top module: `lim_status_word`

## Requirements
- R1: A block covers the valid samples from the cycle with `blk_start` through the cycle with `blk_end`, both cycles included. For each limit, code bit 0 is 1 when some sample of the block is less than or equal to the limit, and code bit 1 is 1 when some sample is greater than or equal to it. Samples and limits are compared as two's-complement signed values. The code values are therefore 1 (at or below only), 2 (at or above only) and 3 (both).
- R2: A sample exactly equal to a limit sets both bits of that limit's code, giving code 3.
- R3: `code_a` is computed only from `lim_a`, and `code_b` only from `lim_b`. The two limits are evaluated independently in the same block.
- R4: When `mon_en` is 0 in the `blk_end` cycle, both published codes are 0, and so are status bits 3 and 2.
- R5: Codes and status word change only in the cycle after a `blk_end` cycle. In every other cycle they hold their value.
- R6: `blk_start` discards everything gathered before it. A block with no valid samples publishes code 0 for both limits and 0 in status bits 1 and 0.
- R7: Status bit 15 is 0 after reset and inverts on every publish.
- R8: Status bit 1 is set when some sample of the block equals 0x7FFF. Status bit 0 is set when some sample equals 0x8000. Status bit 6 equals the OR of bits 1 and 0.
- R9: Status bit 14 is set when `int_err` was high in any cycle of the block. Status bit 13 is set when `sync_err` was high in any cycle of the block.
- R10: Status bit 3 is the OR of the two `code_a` bits, and status bit 2 is the OR of the two `code_b` bits. Bits 12 to 7, 5 and 4 are always 0.
- R11: After reset, `code_a`, `code_b` and `status_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | SMP_W | Calibrated signed sample |
| blk_start | input | 1 | First cycle of a block; clears the gathered results |
| blk_end | input | 1 | Last cycle of a block; publishes the results |
| lim_a | input | SMP_W | Signed threshold for limit A |
| lim_b | input | SMP_W | Signed threshold for limit B |
| mon_en | input | 1 | Limit monitoring enable, sampled at `blk_end` |
| int_err | input | 1 | Internal error indication |
| sync_err | input | 1 | Synchronization error indication |
| code_a | output | 2 | Published result code for limit A |
| code_b | output | 2 | Published result code for limit B |
| status_word | output | 16 | Published status word |

## Verification
Every result goes through exactly one register. The codes and the status word therefore show the block's outcome in the cycle right after the `blk_end` cycle, and the sample on the end cycle itself is part of that outcome. The bench drives inputs on the falling edge. It reads the outputs on the falling edge that follows the rising edge which captured `blk_end`. It reads them again a few cycles later to confirm that they held.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int NUM_LIM = 2;
    localparam int STW     = 16;

    // status word bit positions
    localparam int ST_TOG   = 15;
    localparam int ST_IERR  = 14;
    localparam int ST_SERR  = 13;
    localparam int ST_ERR   = 6;
    localparam int ST_LIMHI = 3;   // limit k lands on ST_LIMHI - k
    localparam int ST_OVR   = 1;
    localparam int ST_UND   = 0;

    typedef struct packed {
        logic ge;
        logic le;
    } lim_hit_t;

    typedef struct packed {
        logic ovr;
        logic und;
        logic ierr;
        logic serr;
    } flags_t;
endpackage

// File: rtl/lsw_limit_acc.sv
module lsw_limit_acc
    import lsw_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             blk_start,
    input  logic [SMP_W-1:0] lim,
    output lim_hit_t         merged
);
    lim_hit_t acc_d, acc_q;
    lim_hit_t base, hit;

    always_comb begin
        base   = blk_start ? '0 : acc_q;
        hit.le = smp_valid && ($signed(smp_data) <= $signed(lim));
        hit.ge = smp_valid && ($signed(smp_data) >= $signed(lim));
        acc_d.le = base.le | hit.le;
        acc_d.ge = base.ge | hit.ge;
        merged   = acc_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/lsw_flag_acc.sv
module lsw_flag_acc
    import lsw_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             blk_start,
    input  logic             int_err,
    input  logic             sync_err,
    output flags_t           merged
);
    localparam logic [SMP_W-1:0] POS_SAT = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_SAT = {1'b1, {(SMP_W-1){1'b0}}};

    flags_t acc_d, acc_q, base;

    always_comb begin
        base       = blk_start ? '0 : acc_q;
        acc_d.ovr  = base.ovr  | (smp_valid && (smp_data == POS_SAT));
        acc_d.und  = base.und  | (smp_valid && (smp_data == NEG_SAT));
        acc_d.ierr = base.ierr | int_err;
        acc_d.serr = base.serr | sync_err;
        merged     = acc_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/lsw_publish.sv
module lsw_publish
    import lsw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          blk_end,
    input  logic                          mon_en,
    input  lim_hit_t [NUM_LIM-1:0]        hits,
    input  flags_t                        flags,
    output logic     [NUM_LIM-1:0][1:0]   codes,
    output logic     [STW-1:0]            status
);
    typedef struct packed {
        logic [NUM_LIM-1:0][1:0] code;
        logic [STW-1:0]          stw;
    } pub_t;

    pub_t pub_d, pub_q;

    always_comb begin
        pub_d = pub_q;
        if (blk_end) begin
            pub_d.stw = '0;
            for (int k = 0; k < NUM_LIM; k++) begin
                pub_d.code[k] = mon_en ? {hits[k].ge, hits[k].le} : 2'b00;
                pub_d.stw[ST_LIMHI-k] = |pub_d.code[k];
            end
            pub_d.stw[ST_TOG]  = ~pub_q.stw[ST_TOG];
            pub_d.stw[ST_IERR] = flags.ierr;
            pub_d.stw[ST_SERR] = flags.serr;
            pub_d.stw[ST_ERR]  = flags.ovr | flags.und;
            pub_d.stw[ST_OVR]  = flags.ovr;
            pub_d.stw[ST_UND]  = flags.und;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pub_q <= '0;
        else        pub_q <= pub_d;
    end

    assign codes  = pub_q.code;
    assign status = pub_q.stw;
endmodule

// File: rtl/lim_status_word.sv
module lim_status_word
    import lsw_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             blk_start,
    input  logic             blk_end,
    input  logic [SMP_W-1:0] lim_a,
    input  logic [SMP_W-1:0] lim_b,
    input  logic             mon_en,
    input  logic             int_err,
    input  logic             sync_err,
    output logic [1:0]       code_a,
    output logic [1:0]       code_b,
    output logic [15:0]      status_word
);
    logic     [NUM_LIM-1:0][SMP_W-1:0] lims;
    lim_hit_t [NUM_LIM-1:0]            hits;
    flags_t                            flags;
    logic     [NUM_LIM-1:0][1:0]       codes;

    assign lims = {lim_b, lim_a};

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        lsw_limit_acc #(.SMP_W(SMP_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_data  (smp_data),
            .blk_start (blk_start),
            .lim       (lims[g]),
            .merged    (hits[g])
        );
    end

    lsw_flag_acc #(.SMP_W(SMP_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .blk_start (blk_start),
        .int_err   (int_err),
        .sync_err  (sync_err),
        .merged    (flags)
    );

    lsw_publish u_pub (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_end (blk_end),
        .mon_en  (mon_en),
        .hits    (hits),
        .flags   (flags),
        .codes   (codes),
        .status  (status_word)
    );

    assign code_a = codes[0];
    assign code_b = codes[1];
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker #(
    parameter int SMP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic             blk_end,
    input logic [SMP_W-1:0] lim_a,
    input logic [SMP_W-1:0] lim_b,
    input logic             mon_en,
    input logic [1:0]       code_a,
    input logic [1:0]       code_b,
    input logic [15:0]      status_word
);
    localparam logic [SMP_W-1:0] POS_SAT = {1'b0, {(SMP_W-1){1'b1}}};

    a_r5_hold_between_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_end |=> ($stable(status_word) && $stable(code_a) && $stable(code_b)));

    a_r7_toggle_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> (status_word[15] != $past(status_word[15])));

    a_r4_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !mon_en) |=> (code_a == 2'b00 && code_b == 2'b00 && status_word[3:2] == 2'b00));

    a_r2_equal_a: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && mon_en && smp_valid && smp_data == lim_a) |=> (code_a == 2'b11));

    a_r2_equal_b: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && mon_en && smp_valid && smp_data == lim_b) |=> (code_b == 2'b11));

    a_r8_ovr_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && smp_valid && smp_data == POS_SAT) |=> (status_word[1] && status_word[6]));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[12:7] == 6'b0 && status_word[5:4] == 2'b0));

    a_r10_limit_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[3] == (|code_a) && status_word[2] == (|code_b)));
endmodule

bind lim_status_word lsw_checker #(.SMP_W(SMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .blk_end     (blk_end),
    .lim_a       (lim_a),
    .lim_b       (lim_b),
    .mon_en      (mon_en),
    .code_a      (code_a),
    .code_b      (code_b),
    .status_word (status_word)
);

// File: tb/lim_status_word_bench.sv
`timescale 1ns/1ps
module lim_status_word_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic              blk_start = 1'b0;
    logic              blk_end = 1'b0;
    logic signed [15:0] lim_a = '0;
    logic signed [15:0] lim_b = '0;
    logic              mon_en = 1'b0;
    logic              int_err = 1'b0;
    logic              sync_err = 1'b0;
    logic [1:0]        code_a;
    logic [1:0]        code_b;
    logic [15:0]       status_word;

    int total = 0;
    int bad   = 0;
    logic tog = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic signed [15:0] sv [16];
    logic               vv [16];

    always #10 clk = ~clk;

    lim_status_word #(.SMP_W(16)) u_lim_status_word (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .blk_start(blk_start), .blk_end(blk_end), .lim_a(lim_a), .lim_b(lim_b),
        .mon_en(mon_en), .int_err(int_err), .sync_err(sync_err),
        .code_a(code_a), .code_b(code_b), .status_word(status_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    // samples with no start/end; R6 says these must not count later
    task automatic feed_stale(input logic signed [15:0] v, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_data = v; int_err = 1'b1; sync_err = 1'b1;
            blk_start = 1'b0; blk_end = 1'b0;
        end
        @(negedge clk);
        smp_valid = 1'b0; int_err = 1'b0; sync_err = 1'b0;
    endtask

    task automatic run_block(input int n, input logic en, input int ie_at, input int se_at,
                             input logic hold_chk, input string tag);
        logic lea = 0, gea = 0, leb = 0, geb = 0, ov = 0, un = 0, ie = 0, se = 0;
        logic [1:0] ca, cb;
        logic [15:0] st;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = vv[i]; smp_data = sv[i];
            blk_start = (i == 0); blk_end = (i == n-1);
            int_err = (i == ie_at); sync_err = (i == se_at); mon_en = en;
            if (vv[i]) begin
                if (sv[i] <= lim_a) lea = 1;
                if (sv[i] >= lim_a) gea = 1;
                if (sv[i] <= lim_b) leb = 1;
                if (sv[i] >= lim_b) geb = 1;
                if (sv[i] == 16'sh7FFF) ov = 1;
                if (sv[i] == -16'sh8000) un = 1;
            end
            if (i == ie_at) ie = 1;
            if (i == se_at) se = 1;
        end
        @(negedge clk);
        smp_valid = 0; blk_start = 0; blk_end = 0; int_err = 0; sync_err = 0;
        tog = ~tog;
        ca = en ? {gea, lea} : 2'b00;
        cb = en ? {geb, leb} : 2'b00;
        st = {tog, ie, se, 6'b0, ov | un, 2'b0, |ca, |cb, ov, un};
        chk({"R1 R3 code_a ", tag}, {14'b0, code_a}, {14'b0, ca});
        chk({"R1 R3 code_b ", tag}, {14'b0, code_b}, {14'b0, cb});
        chk({"R7 R8 R9 R10 status ", tag}, status_word, st);
        if (hold_chk) begin
            repeat (3) @(negedge clk);
            chk({"R5 hold ", tag}, {code_a, code_b, 12'b0}, {ca, cb, 12'b0});
            chk({"R5 hold status ", tag}, status_word, st);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset code_a", {14'b0, code_a}, 16'h0);
        chk("R11 reset code_b", {14'b0, code_b}, 16'h0);
        chk("R11 reset status", status_word, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: single-sample sweep around the limits, both sides and equality
        foreach (sv[i]) begin sv[i] = '0; vv[i] = 1'b0; end
        for (int li = 0; li < 3; li++) begin
            lim_a = (li == 0) ? -16'sd100 : (li == 1) ? 16'sd0 : 16'sd1234;
            lim_b = lim_a + 16'sd2;
            for (int d = -3; d <= 5; d++) begin
                sv[0] = lim_a + 16'(d); vv[0] = 1'b1;
                run_block(1, 1'b1, -1, -1, d == 0, "R2 single");
            end
        end

        // R8: saturation values
        lim_a = 16'sd0; lim_b = 16'sd10;
        sv[0] = 16'sh7FFF; vv[0] = 1; sv[1] = 16'sd3; vv[1] = 1;
        run_block(2, 1'b1, -1, -1, 1'b0, "R8 overrange");
        sv[0] = -16'sh8000; vv[0] = 1;
        run_block(2, 1'b1, -1, -1, 1'b0, "R8 underrange");
        sv[0] = 16'sh7FFF; sv[1] = -16'sh8000;
        run_block(2, 1'b1, -1, -1, 1'b0, "R8 both");

        // R4: monitoring disabled
        sv[0] = 16'sd0; sv[1] = 16'sd10;
        run_block(2, 1'b0, -1, -1, 1'b1, "R4 disabled");

        // R9: error pulses inside a block
        sv[0] = 16'sd5; sv[1] = 16'sd6; vv[2] = 1; sv[2] = 16'sd7;
        run_block(3, 1'b1, 1, -1, 1'b0, "R9 int_err");
        run_block(3, 1'b1, -1, 2, 1'b0, "R9 sync_err");

        // R6: stale samples discarded, empty block
        feed_stale(16'sh7FFF, 4);
        sv[0] = 16'sd4; sv[1] = 16'sd5; vv[2] = 0;
        run_block(3, 1'b1, -1, -1, 1'b0, "R6 stale cleared");
        vv[0] = 0;
        run_block(1, 1'b1, -1, -1, 1'b1, "R6 empty block");

        // R1 R3: pseudo-random multi-sample blocks with gaps
        lim_a = -16'sd5; lim_b = 16'sd7;
        for (int b = 0; b < 60; b++) begin
            int n;
            n = int'(next_rand() % 16'd8) + 1;
            for (int i = 0; i < n; i++) begin
                sv[i] = 16'(int'(next_rand() % 16'd41) - 20);
                vv[i] = next_rand() % 16'd4 != 0;
            end
            run_block(n, (b % 7) != 3, -1, -1, (b % 10) == 0, "R1 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule